// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide register port of a programmable interrupt controller. Software reaches it through a one-bit address. Writes to address 0 fall into three groups: a start-of-setup word, a mode command, or a command handed on to the end-of-interrupt and rotation logic. Writes to address 1 are steered by a small setup sequencer. While setup is in progress they supply the vector base, a word that is consumed, and an optional mode word. Once setup is complete they load the interrupt mask.

Reads return one of three things: the mask, the pending-request register, or the in-service register. The register owned by the request and priority logic is chosen by a read-select flag. When poll mode is armed, one read returns the index of the winning request instead. That read also emits an acknowledge strobe so that the neighbouring logic clears the winner's request and in-service bits.

Priority resolution is not part of this block. The winner arrives as a valid flag and an index. The block drives the setup-start strobe and the acknowledge strobes toward the neighbouring logic. It also drives the configuration outputs: vector base, automatic end-of-interrupt, special nesting, mask and special mask.

Top module: `pic_reg_port`

## Requirements
- R1: After reset the mask, vector base, automatic end-of-interrupt, special nesting, special mask, read-select and poll flags are all 0, and the sequencer is idle, so a write to address 1 loads the mask.
- R2: A write to address 0 with bit 4 set pulses `setup_start` in its own cycle. It clears the mask, vector base, both mode flags, special mask, read-select and poll. It records bit 0 as "mode word follows" and makes the next address-1 write the vector-base word.
- R3: The vector-base word sets `vec_base` to the written byte with its low log2(LANES) bits cleared (bits 2:0 for eight lines).
- R4: The address-1 write after the vector-base word is consumed without effect. If no mode word was requested, the sequencer then returns to idle.
- R5: When a mode word was requested, the next address-1 write sets `spec_nested` from bit 4 and `auto_eoi` from bit 1, then returns the sequencer to idle.
- R6: An address-1 write while idle loads the mask from the low LANES bits. During setup, address-1 writes never change the mask.
- R7: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 1 set loads read-select from bit 0. Bit 6 set loads the special mask from bit 5. Bit 2 set arms poll mode. Bits that are not enabled leave the flags unchanged.
- R8: With poll disarmed, a read of address 1 returns the mask. A read of address 0 returns `isr_vec` when read-select is 1 and `req_vec` when it is 0. Upper bits above LANES read as 0.
- R9: With poll armed, the next read at either address returns `win_idx` and pulses `poll_ack` with `poll_ack_idx = win_idx` if `win_valid` is 1. Otherwise it returns 7 with no acknowledge. Poll is then disarmed.
- R10: An address-0 write with bits 4 and 3 both clear pulses `eoi_stb` in its own cycle with `eoi_data` equal to the byte. It changes no register of this block.
- R11: A setup-start word written in the middle of a setup sequence restarts the sequence, so the next address-1 write is again the vector-base word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| rd_stb | input | 1 | Read strobe; side effects on the clock edge |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, combinational from state |
| req_vec | input | LANES | Pending-request register from request logic |
| isr_vec | input | LANES | In-service register from priority logic |
| win_valid | input | 1 | A winning request exists |
| win_idx | input | IDX_W | Index of the winning request |
| vec_base | output | 8 | Vector base |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| spec_nested | output | 1 | Special nesting mode |
| mask | output | LANES | Interrupt mask |
| spec_mask | output | 1 | Special mask mode |
| setup_start | output | 1 | Clear request/priority state and force output low |
| eoi_stb | output | 1 | End-of-interrupt/rotation command strobe |
| eoi_data | output | 8 | Command byte for that path |
| poll_ack | output | 1 | Acknowledge of the polled winner |
| poll_ack_idx | output | IDX_W | Index to clear in request and in-service |

## Verification
The vector-base word is swept over all 256 bytes, and the same byte also serves as the mode word. This separates the kept high bits from the cleared low bits, and bit 4 from bit 1 of the mode word. The mode command is swept over all sixteen combinations of its enable and value bits against a running model, which shows whether each flag loads only under its own enable. Every command byte with bits 4 and 3 clear is driven to confirm forwarding and no side effects. Poll reads are tried with each winner index and with no winner. Setup sequences with and without the mode word, and a restarted sequence, show whether address-1 writes are steered to the right target.

// File: rtl/pic_port_pkg.sv
package pic_port_pkg;
    localparam int BYTE_W = 8;

    // command bit positions in address-0 writes
    localparam int B_SETUP   = 4;
    localparam int B_MODECMD = 3;
    localparam int B_POLL    = 2;
    localparam int B_RSEL_EN = 1;
    localparam int B_RSEL    = 0;
    localparam int B_SMSK_EN = 6;
    localparam int B_SMSK    = 5;
    localparam int B_NEED4   = 0;

    // mode word bit positions
    localparam int B_NEST    = 4;
    localparam int B_AEOI    = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BASE = 2'd1,
        ST_SKIP = 2'd2,
        ST_MODE = 2'd3
    } setup_st_e;
endpackage

// File: rtl/pic_setup_seq.sv
module pic_setup_seq
    import pic_port_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] vec_base,
    output logic              auto_eoi,
    output logic              spec_nested,
    output logic [LANES-1:0]  mask,
    output logic              setup_start
);
    localparam int IDX_W = $clog2(LANES);
    localparam logic [BYTE_W-1:0] BASE_KEEP = 8'hFF << IDX_W;

    typedef struct packed {
        setup_st_e          st;
        logic               need4;
        logic [BYTE_W-1:0]  base;
        logic               aeoi;
        logic               nest;
        logic [LANES-1:0]   msk;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        setup_start = 1'b0;
        if (wr_stb && !addr && wdata[B_SETUP]) begin
            setup_start  = 1'b1;
            seq_d.st     = ST_BASE;
            seq_d.need4  = wdata[B_NEED4];
            seq_d.base   = '0;
            seq_d.aeoi   = 1'b0;
            seq_d.nest   = 1'b0;
            seq_d.msk    = '0;
        end else if (wr_stb && addr) begin
            case (seq_q.st)
                ST_IDLE: seq_d.msk = wdata[LANES-1:0];
                ST_BASE: begin
                    seq_d.base = wdata & BASE_KEEP;
                    seq_d.st   = ST_SKIP;
                end
                ST_SKIP: seq_d.st = seq_q.need4 ? ST_MODE : ST_IDLE;
                ST_MODE: begin
                    seq_d.nest = wdata[B_NEST];
                    seq_d.aeoi = wdata[B_AEOI];
                    seq_d.st   = ST_IDLE;
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st    <= ST_IDLE;
            seq_q.need4 <= 1'b0;
            seq_q.base  <= '0;
            seq_q.aeoi  <= 1'b0;
            seq_q.nest  <= 1'b0;
            seq_q.msk   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign vec_base    = seq_q.base;
    assign auto_eoi    = seq_q.aeoi;
    assign spec_nested = seq_q.nest;
    assign mask        = seq_q.msk;

    // R2
    setup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !addr && wdata[B_SETUP]) |=>
            (mask == '0 && vec_base == '0 && !auto_eoi && !spec_nested && seq_q.st == ST_BASE));

    // R3
    base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_BASE && wr_stb && addr) |=> (seq_q.st == ST_SKIP));

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_IDLE && wr_stb && addr) |=> $stable(mask));
endmodule

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
    import pic_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              read_sel,
    output logic              poll_armed,
    output logic              spec_mask,
    output logic              eoi_stb,
    output logic [BYTE_W-1:0] eoi_data
);
    typedef struct packed {
        logic rsel;
        logic poll;
        logic smsk;
    } cmd_t;

    cmd_t cmd_d, cmd_q;
    logic arm_now;

    always_comb begin
        cmd_d   = cmd_q;
        eoi_stb = 1'b0;
        arm_now = 1'b0;
        if (rd_stb && cmd_q.poll)
            cmd_d.poll = 1'b0;
        if (wr_stb && !addr) begin
            if (wdata[B_SETUP]) begin
                cmd_d = '0;
            end else if (wdata[B_MODECMD]) begin
                if (wdata[B_POLL]) begin
                    cmd_d.poll = 1'b1;
                    arm_now    = 1'b1;
                end
                if (wdata[B_RSEL_EN]) cmd_d.rsel = wdata[B_RSEL];
                if (wdata[B_SMSK_EN]) cmd_d.smsk = wdata[B_SMSK];
            end else begin
                eoi_stb = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign read_sel   = cmd_q.rsel;
    assign poll_armed = cmd_q.poll;
    assign spec_mask  = cmd_q.smsk;
    assign eoi_data   = wdata;

    // R10
    eoi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_stb |=> ($stable(read_sel) && $stable(spec_mask)));

    // R9
    poll_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && poll_armed && !arm_now) |=> !poll_armed);
endmodule

// File: rtl/pic_read_mux.sv
module pic_read_mux
    import pic_port_pkg::*;
#(
    parameter int LANES = 8,
    parameter int IDX_W = 3
) (
    input  logic              rd_stb,
    input  logic              addr,
    input  logic              poll_armed,
    input  logic              read_sel,
    input  logic [LANES-1:0]  req_vec,
    input  logic [LANES-1:0]  isr_vec,
    input  logic [LANES-1:0]  mask,
    input  logic              win_valid,
    input  logic [IDX_W-1:0]  win_idx,
    output logic [BYTE_W-1:0] rdata,
    output logic              poll_ack,
    output logic [IDX_W-1:0]  poll_ack_idx
);
    localparam logic [BYTE_W-1:0] NONE_CODE = 8'd7;

    always_comb begin
        rdata = '0;
        if (poll_armed) begin
            if (win_valid) rdata[IDX_W-1:0] = win_idx;
            else           rdata = NONE_CODE;
        end else if (addr) begin
            rdata[LANES-1:0] = mask;
        end else if (read_sel) begin
            rdata[LANES-1:0] = isr_vec;
        end else begin
            rdata[LANES-1:0] = req_vec;
        end
    end

    assign poll_ack     = rd_stb && poll_armed && win_valid;
    assign poll_ack_idx = win_idx;
endmodule

// File: rtl/pic_reg_port.sv
module pic_reg_port
    import pic_port_pkg::*;
#(
    parameter int LANES = 8,
    parameter int IDX_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [LANES-1:0]  req_vec,
    input  logic [LANES-1:0]  isr_vec,
    input  logic              win_valid,
    input  logic [IDX_W-1:0]  win_idx,
    output logic [7:0]        vec_base,
    output logic              auto_eoi,
    output logic              spec_nested,
    output logic [LANES-1:0]  mask,
    output logic              spec_mask,
    output logic              setup_start,
    output logic              eoi_stb,
    output logic [7:0]        eoi_data,
    output logic              poll_ack,
    output logic [IDX_W-1:0]  poll_ack_idx
);
    logic read_sel;
    logic poll_armed;

    pic_setup_seq #(.LANES(LANES)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr), .wdata(wdata),
        .vec_base(vec_base), .auto_eoi(auto_eoi), .spec_nested(spec_nested),
        .mask(mask), .setup_start(setup_start)
    );

    pic_cmd_decode u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr),
        .wdata(wdata), .read_sel(read_sel), .poll_armed(poll_armed),
        .spec_mask(spec_mask), .eoi_stb(eoi_stb), .eoi_data(eoi_data)
    );

    pic_read_mux #(.LANES(LANES), .IDX_W(IDX_W)) u_rd (
        .rd_stb(rd_stb), .addr(addr), .poll_armed(poll_armed), .read_sel(read_sel),
        .req_vec(req_vec), .isr_vec(isr_vec), .mask(mask), .win_valid(win_valid),
        .win_idx(win_idx), .rdata(rdata), .poll_ack(poll_ack),
        .poll_ack_idx(poll_ack_idx)
    );

    // R9
    poll_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && poll_armed && !win_valid) |-> (rdata == 8'd7 && !poll_ack));

    // R8
    mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !poll_armed && addr) |-> (rdata[LANES-1:0] == mask));
endmodule

// File: tb/tb_pic_reg_port.sv
`timescale 1ns/1ps
module tb_pic_reg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0, rd_stb = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] req_vec = 8'hA5, isr_vec = 8'h3C;
    logic       win_valid = 1'b0;
    logic [2:0] win_idx = '0;
    logic [7:0] vec_base, eoi_data, mask;
    logic       auto_eoi, spec_nested, spec_mask, setup_start, eoi_stb, poll_ack;
    logic [2:0] poll_ack_idx;

    int checks = 0, errors = 0;
    bit done = 0;
    logic s_init, s_eoi;
    logic [7:0] s_eoid;

    always #2 clk = ~clk;

    pic_reg_port dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr),
        .wdata(wdata), .rdata(rdata), .req_vec(req_vec), .isr_vec(isr_vec),
        .win_valid(win_valid), .win_idx(win_idx), .vec_base(vec_base),
        .auto_eoi(auto_eoi), .spec_nested(spec_nested), .mask(mask),
        .spec_mask(spec_mask), .setup_start(setup_start), .eoi_stb(eoi_stb),
        .eoi_data(eoi_data), .poll_ack(poll_ack), .poll_ack_idx(poll_ack_idx)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_stb = 1'b1;
        #1;
        s_init = setup_start; s_eoi = eoi_stb; s_eoid = eoi_data;
        @(posedge clk); #1;
        wr_stb = 1'b0;
    endtask

    task automatic do_rd(input logic a, output logic [7:0] v, output logic ack,
                         output logic [2:0] ai);
        @(negedge clk);
        addr = a; rd_stb = 1'b1;
        #1;
        v = rdata; ack = poll_ack; ai = poll_ack_idx;
        @(posedge clk); #1;
        rd_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic ack;
        logic [2:0] ai;
        logic rs_m, sm_m;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 vec_base", vec_base, 0);
        chk("R1 mask", mask, 0);
        chk("R1 auto_eoi", auto_eoi, 0);
        chk("R1 spec_nested", spec_nested, 0);
        chk("R1 spec_mask", spec_mask, 0);
        do_rd(1'b0, v, ack, ai);
        chk("R1 read_sel=0 gives req", v, 8'hA5);
        chk("R1 no poll ack", ack, 0);
        do_wr(1'b1, 8'h96);
        chk("R1 idle loads mask", mask, 8'h96);

        // R2 R3 R5 R6 sweep of the base and mode words
        for (int d = 0; d < 256; d++) begin
            do_wr(1'b0, 8'h11);
            chk("R2 setup_start pulse", s_init, 1);
            chk("R2 mask cleared", mask, 0);
            chk("R2 vec_base cleared", vec_base, 0);
            do_wr(1'b1, d[7:0]);
            chk("R3 vec_base", vec_base, d & 8'hF8);
            chk("R6 mask held during base word", mask, 0);
            do_wr(1'b1, 8'hFF);
            chk("R6 mask held during skip word", mask, 0);
            do_wr(1'b1, d[7:0]);
            chk("R5 spec_nested", spec_nested, (d >> 4) & 1);
            chk("R5 auto_eoi", auto_eoi, (d >> 1) & 1);
            chk("R6 mask held during mode word", mask, 0);
            do_wr(1'b1, ~d[7:0]);
            chk("R6 mask loaded when idle", mask, (~d) & 8'hFF);
            do_rd(1'b1, v, ack, ai);
            chk("R8 mask readback", v, (~d) & 8'hFF);
        end

        // R4 setup without a mode word
        do_wr(1'b0, 8'h10);
        do_wr(1'b1, 8'h48);
        do_wr(1'b1, 8'h12);
        do_wr(1'b1, 8'h3E);
        chk("R4 mask loaded after skip", mask, 8'h3E);
        chk("R4 spec_nested unchanged", spec_nested, 0);
        chk("R4 auto_eoi unchanged", auto_eoi, 0);
        chk("R4 vec_base", vec_base, 8'h48);

        // R11 restart mid-sequence
        do_wr(1'b0, 8'h11);
        do_wr(1'b1, 8'h40);
        do_wr(1'b0, 8'h11);
        chk("R11 vec_base cleared by restart", vec_base, 0);
        do_wr(1'b1, 8'h8B);
        chk("R11 base word again", vec_base, 8'h88);
        do_wr(1'b1, 8'h00);
        do_wr(1'b1, 8'h12);
        chk("R11 spec_nested", spec_nested, 1);
        chk("R11 auto_eoi", auto_eoi, 1);
        do_wr(1'b1, 8'hC3);
        chk("R11 mask after restart", mask, 8'hC3);

        // R7 mode command sweep; R8 read-select
        rs_m = 1'b0; sm_m = 1'b0;
        for (int k = 0; k < 16; k++) begin
            logic [7:0] c;
            c = 8'h08 | (k[0] ? 8'h01 : 8'h00) | (k[1] ? 8'h02 : 8'h00)
                      | (k[2] ? 8'h20 : 8'h00) | (k[3] ? 8'h40 : 8'h00);
            do_wr(1'b0, c);
            if (c[1]) rs_m = c[0];
            if (c[6]) sm_m = c[5];
            chk("R7 no eoi for mode cmd", s_eoi, 0);
            chk("R7 spec_mask", spec_mask, sm_m);
            do_rd(1'b0, v, ack, ai);
            chk("R8 addr0 read by read_sel", v, rs_m ? 8'h3C : 8'hA5);
            do_rd(1'b1, v, ack, ai);
            chk("R8 addr1 reads mask", v, 8'hC3);
        end

        // R9 poll with each winner index
        for (int i = 0; i < 8; i++) begin
            win_valid = 1'b1; win_idx = i[2:0];
            do_wr(1'b0, 8'h0C);
            do_rd(i[0], v, ack, ai);
            chk("R9 poll returns winner", v, i);
            chk("R9 poll ack", ack, 1);
            chk("R9 poll ack idx", ai, i);
            do_rd(1'b1, v, ack, ai);
            chk("R9 disarmed after one read", v, 8'hC3);
            chk("R9 no second ack", ack, 0);
        end
        win_valid = 1'b0;
        do_wr(1'b0, 8'h0C);
        do_rd(1'b0, v, ack, ai);
        chk("R9 empty poll returns 7", v, 7);
        chk("R9 empty poll no ack", ack, 0);
        do_rd(1'b1, v, ack, ai);
        chk("R9 disarmed after empty poll", v, 8'hC3);

        // R10 end-of-interrupt forwarding
        for (int j = 0; j < 256; j++) begin
            logic [7:0] b;
            b = j[7:0];
            if (b[4] == 1'b0 && b[3] == 1'b0) begin
                do_wr(1'b0, b);
                chk("R10 eoi strobe", s_eoi, 1);
                chk("R10 eoi data", s_eoid, b);
                chk("R10 spec_mask unchanged", spec_mask, sm_m);
                chk("R10 mask unchanged", mask, 8'hC3);
                do_rd(1'b0, v, ack, ai);
                chk("R10 read_sel unchanged", v, rs_m ? 8'h3C : 8'hA5);
            end
        end

        finish_run();
    end
endmodule